// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block runs one DRAM bus cycle for each accepted request. The cycle is a normal read, a normal write, or a CAS-before-RAS refresh. It captures the request fields when the request is accepted. It then steps through one or two precharge states, a row state and two column states. A refresh replaces the row and column states with three refresh states.

Along the way it drives the following:
- a per-area active-low row strobe, taken from the chosen area's select line;
- separate upper and lower column strobes, one per byte lane;
- a shared write-enable;
- the data-out enable;
- a multiplexed row/column address.

Read data is captured at the end of the last column state.

A control input chooses the number of precharge states. It is latched with the request, so that every cycle, refresh included, opens with a precharge phase of a known length while all row strobes are high. The sequencer reports that it is busy for the whole cycle and pulses a done flag in the final state. Requests that arrive while it is busy are dropped.

Top module: `dram_cycle_seq`

## Requirements
- R1: While rst_ni is low: busy_o, done_o, dout_en_o and rvalid_o are 0; every ras_n_o bit, ucas_n_o, lcas_n_o and we_n_o are 1; ma_o is 0.
- R2: An accepted cycle opens with precharge states. There is one precharge state when two_pre_i was 0 at acceptance and two when it was 1. In these states all ras_n_o bits, both CAS strobes and we_n_o are high, and ma_o is 0.
- R3: A request is accepted at a clock edge where req_i is high and busy_o is low. busy_o is then high from the next cycle for exactly (precharge count + 3) cycles. done_o is high only in the last of these cycles.
- R4: area_i is a binary index. For a read or write, ras_n_o[area] is low in the row state and in both column states. For a refresh, it is low in the last two refresh states. All other ras_n_o bits stay high.
- R5: For reads and writes, ma_o carries addr_i[COL_W+ROW_W-1:COL_W] in the row state and addr_i[COL_W-1:0] in both column states. It is 0 in all other states.
- R6: For reads and writes, ucas_n_o is low only in the second column state and only if lane_i[1]=1. lcas_n_o follows the same rule with lane_i[0].
- R7: req_kind_i encoding: 2'b00 read, 2'b01 write, 2'b1x refresh. For a write, dout_en_o is high from the row state through the second column state, and we_n_o is low in both column states. Reads and refreshes keep dout_en_o low and we_n_o high.
- R8: For a read, din_i is captured at the end of the second column state. rdata_o holds it, and rvalid_o is high for exactly the one following cycle.
- R9: For a refresh, both CAS strobes are low in all three refresh states, the row strobe is still high in the first, and ma_o is 0. Lane selection does not affect the strobes.
- R10: Request inputs (kind, lanes, area, address) that change while busy_o is high, including in the done cycle, do not alter the running cycle and start no new cycle.
- R11: two_pre_i changes after acceptance do not alter the current cycle's precharge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | 00 read, 01 write, 1x refresh |
| lane_i | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| addr_i | input | ROW_W+COL_W | Full DRAM address, row above column |
| area_i | input | AREA_W | Area index choosing the row strobe |
| two_pre_i | input | 1 | 1 selects two precharge states |
| din_i | input | DATA_W | Read data from the DRAM |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Final state of the cycle |
| ras_n_o | output | NUM_AREA | Active-low row strobe per area |
| ucas_n_o | output | 1 | Upper-lane column strobe, active low |
| lcas_n_o | output | 1 | Lower-lane column strobe, active low |
| we_n_o | output | 1 | Write-enable, active low |
| dout_en_o | output | 1 | Write data drive enable |
| ma_o | output | MA_W | Multiplexed row/column address |
| rdata_o | output | DATA_W | Captured read data |
| rvalid_o | output | 1 | rdata_o updated last edge |

## Verification
Two events can meet in the same cycle: the final state of a cycle, marked by done_o, and a new request. The bench holds req_i high through every cycle's done state, with fields and the precharge control altered in the cycle after acceptance. It then checks, in the cycle after done, that busy_o is low, that all strobes are idle, and that the read-data result belongs to the finished cycle. A wrongly accepted request would raise busy_o again or move the strobes, and that shows up as a miscompare.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE1, ST_PRE2, ST_ROW, ST_COL1, ST_COL2, ST_REF1, ST_REF2, ST_REF3
  } seq_state_e;

  function automatic logic is_refresh(input logic [1:0] kind);
    return kind[1];
  endfunction

  function automatic logic is_write(input logic [1:0] kind);
    return !kind[1] && kind[0];
  endfunction

  function automatic logic is_read(input logic [1:0] kind);
    return kind == 2'b00;
  endfunction
endpackage

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREA_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        lane_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic              two_pre_i,
  output seq_state_e        state_o,
  output logic [1:0]        kind_q_o,
  output logic [1:0]        lane_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [AREA_W-1:0] area_q_o
);
  seq_state_e state_q, state_d, after_pre;
  logic       two_q;
  logic       accept;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign after_pre = is_refresh(kind_q_o) ? ST_REF1 : ST_ROW;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_PRE1;
      ST_PRE1: state_d = two_q ? ST_PRE2 : after_pre;
      ST_PRE2: state_d = after_pre;
      ST_ROW:  state_d = ST_COL1;
      ST_COL1: state_d = ST_COL2;
      ST_COL2: state_d = ST_IDLE;
      ST_REF1: state_d = ST_REF2;
      ST_REF2: state_d = ST_REF3;
      ST_REF3: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      two_q    <= 1'b0;
      kind_q_o <= '0;
      lane_q_o <= '0;
      addr_q_o <= '0;
      area_q_o <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        two_q    <= two_pre_i;
        kind_q_o <= kind_i;
        lane_q_o <= lane_i;
        addr_q_o <= addr_i;
        area_q_o <= area_i;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dram_seq_addr_mux.sv
module dram_seq_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  output logic [MA_W-1:0]   ma_o
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign row = addr_q_i[COL_W +: ROW_W];
  assign col = addr_q_i[COL_W-1:0];

  always_comb begin
    unique case (state_i)
      ST_ROW:           ma_o = MA_W'(row);
      ST_COL1, ST_COL2: ma_o = MA_W'(col);
      default:          ma_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
  import dram_seq_pkg::*;
#(
  parameter int NUM_AREA = 4,
  localparam int AREA_W = (NUM_AREA > 1) ? $clog2(NUM_AREA) : 1
) (
  input  seq_state_e          state_i,
  input  logic [1:0]          kind_q_i,
  input  logic [1:0]          lane_q_i,
  input  logic [AREA_W-1:0]   area_q_i,
  output logic [NUM_AREA-1:0] ras_n_o,
  output logic                ucas_n_o,
  output logic                lcas_n_o,
  output logic                we_n_o,
  output logic                dout_en_o,
  output logic                busy_o,
  output logic                done_o
);
  logic ras_phase, col_phase, ref_phase, wr;

  assign wr        = is_write(kind_q_i);
  assign col_phase = (state_i == ST_COL1) || (state_i == ST_COL2);
  assign ref_phase = (state_i == ST_REF1) || (state_i == ST_REF2) || (state_i == ST_REF3);
  assign ras_phase = (state_i == ST_ROW) || col_phase ||
                     (state_i == ST_REF2) || (state_i == ST_REF3);

  for (genvar g = 0; g < NUM_AREA; g++) begin : g_ras
    assign ras_n_o[g] = !(ras_phase && (area_q_i == AREA_W'(g)));
  end

  // refresh: CAS leads RAS by one state; access: CAS only in last column state
  assign ucas_n_o  = !(ref_phase || ((state_i == ST_COL2) && lane_q_i[1]));
  assign lcas_n_o  = !(ref_phase || ((state_i == ST_COL2) && lane_q_i[0]));
  assign we_n_o    = !(wr && col_phase);
  assign dout_en_o = wr && ((state_i == ST_ROW) || col_phase);
  assign busy_o    = state_i != ST_IDLE;
  assign done_o    = (state_i == ST_COL2) || (state_i == ST_REF3);
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_AREA = 4,
  parameter int ROW_W    = 8,
  parameter int COL_W    = 8,
  parameter int DATA_W   = 16,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int AREA_W  = (NUM_AREA > 1) ? $clog2(NUM_AREA) : 1,
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [1:0]          req_kind_i,
  input  logic [1:0]          lane_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [AREA_W-1:0]   area_i,
  input  logic                two_pre_i,
  input  logic [DATA_W-1:0]   din_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [NUM_AREA-1:0] ras_n_o,
  output logic                ucas_n_o,
  output logic                lcas_n_o,
  output logic                we_n_o,
  output logic                dout_en_o,
  output logic [MA_W-1:0]     ma_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);
  seq_state_e        state;
  logic [1:0]        kind_q, lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AREA_W-1:0] area_q;

  dram_seq_fsm #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_fsm (
    .clk_i, .rst_ni, .req_i,
    .kind_i(req_kind_i), .lane_i, .addr_i, .area_i, .two_pre_i,
    .state_o(state), .kind_q_o(kind_q), .lane_q_o(lane_q),
    .addr_q_o(addr_q), .area_q_o(area_q)
  );

  dram_seq_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .state_i(state), .addr_q_i(addr_q), .ma_o
  );

  dram_seq_strobe #(.NUM_AREA(NUM_AREA)) u_strb (
    .state_i(state), .kind_q_i(kind_q), .lane_q_i(lane_q), .area_q_i(area_q),
    .ras_n_o, .ucas_n_o, .lcas_n_o, .we_n_o, .dout_en_o, .busy_o, .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      if (state == ST_COL2 && is_read(kind_q)) begin
        rdata_o  <= din_i;
        rvalid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int NUM_AREA = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_o,
  input logic                done_o,
  input logic [NUM_AREA-1:0] ras_n_o,
  input logic                ucas_n_o,
  input logic                lcas_n_o,
  input logic                we_n_o,
  input logic                dout_en_o,
  input logic                rvalid_o
);
  a_r2_pre_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$past(busy_o) |-> (&ras_n_o) && ucas_n_o && lcas_n_o && we_n_o);

  a_r4_one_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ras_n_o));

  a_r3_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r3_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r7_we_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> dout_en_o);

  a_r8_rvalid_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(done_o) && !busy_o);

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

bind dram_cycle_seq dram_seq_chk #(.NUM_AREA(NUM_AREA)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .ras_n_o(ras_n_o), .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o),
  .we_n_o(we_n_o), .dout_en_o(dout_en_o), .rvalid_o(rvalid_o)
);

// File: tb/dram_cycle_seq_tb_top.sv
module dram_cycle_seq_tb_top;
  localparam int NUM_AREA = 4;
  localparam int ROW_W = 8;
  localparam int COL_W = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int AREA_W = 2;
  localparam int MA_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [1:0] req_kind_i = '0;
  logic [1:0] lane_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [AREA_W-1:0] area_i = '0;
  logic two_pre_i = 1'b0;
  logic [DATA_W-1:0] din_i = '0;
  logic busy_o, done_o, ucas_n_o, lcas_n_o, we_n_o, dout_en_o, rvalid_o;
  logic [NUM_AREA-1:0] ras_n_o;
  logic [MA_W-1:0] ma_o;
  logic [DATA_W-1:0] rdata_o;

  int vecs = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  dram_cycle_seq #(.NUM_AREA(NUM_AREA), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
    .clk_i, .rst_ni, .req_i, .req_kind_i, .lane_i, .addr_i, .area_i, .two_pre_i,
    .din_i, .busy_o, .done_o, .ras_n_o, .ucas_n_o, .lcas_n_o, .we_n_o, .dout_en_o,
    .ma_o, .rdata_o, .rvalid_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic [1:0] kind, input logic two, input logic [1:0] lanes,
                         input logic [1:0] area, input logic [15:0] addr, input logic [15:0] data);
    int np, len, ph;
    logic pre, refr, wr, ras_low;
    logic [3:0] exp_ras;
    logic [7:0] exp_ma;
    @(negedge clk_i);
    req_i = 1'b1; req_kind_i = kind; lane_i = lanes; area_i = area;
    addr_i = addr; two_pre_i = two; din_i = data;
    np = two ? 2 : 1;
    len = np + 3;
    refr = kind[1];
    wr = !kind[1] && kind[0];
    for (int t = 0; t < len; t++) begin
      @(negedge clk_i);
      if (t == 0) begin
        // R10 R11: disturb request fields while busy; req_i stays high
        req_kind_i = kind ^ 2'b01; lane_i = ~lanes; area_i = area + 2'd1;
        addr_i = ~addr; two_pre_i = ~two;
      end
      pre = t < np;
      ph = t - np;
      ras_low = !pre && (refr ? (ph >= 1) : 1'b1);
      exp_ras = 4'hF;
      if (ras_low) exp_ras[area] = 1'b0;
      if (!refr && ph == 0) exp_ma = addr[15:8];
      else if (!refr && ph >= 1) exp_ma = addr[7:0];
      else exp_ma = 8'h00;
      chk("R3 busy", 32'(busy_o), 32'd1);
      chk("R3 done", 32'(done_o), 32'(t == len - 1));
      chk(pre ? "R2 ras_n" : (refr ? "R9 ras_n" : "R4 ras_n"), 32'(ras_n_o), 32'(exp_ras));
      chk(refr ? "R9 ma" : "R5 ma", 32'(ma_o), 32'(exp_ma));
      chk(refr ? "R9 ucas_n" : "R6 ucas_n", 32'(ucas_n_o),
          32'(!(refr ? !pre : (ph == 2 && lanes[1]))));
      chk(refr ? "R9 lcas_n" : "R6 lcas_n", 32'(lcas_n_o),
          32'(!(refr ? !pre : (ph == 2 && lanes[0]))));
      chk("R7 we_n", 32'(we_n_o), 32'(!(wr && (ph == 1 || ph == 2))));
      chk("R7 dout_en", 32'(dout_en_o), 32'(wr && !pre));
    end
    @(negedge clk_i);
    // request still high through the done edge: must not restart (R10)
    chk("R10 idle busy", 32'(busy_o), 32'd0);
    chk("R10 idle ras_n", 32'(ras_n_o), 32'hF);
    chk("R8 rvalid", 32'(rvalid_o), 32'(kind == 2'b00));
    if (kind == 2'b00) chk("R8 rdata", 32'(rdata_o), 32'(data));
    req_i = 1'b0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 ras_n", 32'(ras_n_o), 32'hF);
    chk("R1 cas", 32'({ucas_n_o, lcas_n_o, we_n_o}), 32'h7);
    chk("R1 dout_en", 32'(dout_en_o), 32'd0);
    chk("R1 ma", 32'(ma_o), 32'd0);
    chk("R1 rvalid", 32'(rvalid_o), 32'd0);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int tp = 0; tp < 2; tp++)
        for (int ln = 0; ln < 4; ln++)
          for (int ar = 0; ar < 4; ar++) begin
            int idx;
            logic [15:0] a;
            idx = ((k * 2 + tp) * 4 + ln) * 4 + ar;
            a = 16'(idx * 16'h3B5 + 16'h1234);
            run_txn(2'(k), tp[0], 2'(ln), 2'(ar), a, ~a ^ 16'(idx));
          end
    report();
    $finish;
  end
endmodule